// File: doc/BRIEF.md
# Serial-to-Parallel Frame Deserializer

This block turns a continuous one-bit serial stream into N-bit parallel words, one word every N clock cycles, for a downstream transform stage that works on whole vectors. A new serial bit is taken on every rising clock edge once reset is released. No sync word or handshake is involved: the framing comes only from the moment reset is released.

A free-running frame counter, log2(N) bits wide, runs from that moment. It marks the last bit position of each frame. On that edge, the N most recent bits, including the one arriving on that edge, are copied into a held output register, and a one-cycle valid strobe is raised. Between strobes the parallel word does not change.

Top module: `ser2par_deser`

## Requirements
- R1: On every rising clock edge while reset is released, the value on `ser_i` is captured. No edge is skipped and no bit is captured twice.
- R2: The frame counter is log2(N) bits wide and is 0 when reset is released. The first frame is made of the bits captured on the first N rising edges after release, and each later frame is made of the next N.
- R3: On the last edge of each frame (every Nth edge after release), `data_o` is loaded with the N bits of that frame, including the bit captured on that same edge.
- R4: Bit order: within a frame, the first bit captured lands in `data_o[0]` and the last lands in `data_o[N-1]`.
- R5: `valid_o` is high for exactly one cycle, namely the cycle that follows each reload of `data_o`. It is low in every other cycle.
- R6: `data_o` holds its value in every cycle that does not follow a reload.
- R7: While `rst_ni` is low (asynchronous, active low), the counter, the shift register, `data_o` and `valid_o` are all 0. Asserting reset in the middle of a frame discards the partial frame, and framing restarts from the next release.
- R8: N is a parameter, a power of two of at least 2, with a default of 8 (a 3-bit counter).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data, one bit per clock |
| data_o | output | N | Parallel word of the last complete frame; first bit of the frame in bit 0 |
| valid_o | output | 1 | One-cycle strobe in the cycle after `data_o` is reloaded |

## Verification
A bit driven before rising edge k after release belongs to frame (k-1)/N. The word for frame f appears on `data_o` right after edge N·(f+1), and `valid_o` rises after that same edge and falls after the next one. The bench drives `ser_i` and samples both outputs on falling edges, so every sample falls half a period after the edge that produced it. Each sample is compared with the frame word the bench built itself, or with the held previous word. All 2^N frame patterns are sent back to back, and the bench then applies a reset in the middle of a frame to check that framing restarts.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;
  function automatic bit is_pow2(input int v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/s2p_frame_ctr.sv
module s2p_frame_ctr #(
  parameter int N = 8,
  localparam int M = $clog2(N)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o
);
  logic [M-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;  // power-of-two N wraps naturally
  end

  assign last_o = (cnt_q == M'(N - 1));

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cnt_q == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/s2p_shift_reg.sv
module s2p_shift_reg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic [N-1:0] next_o
);
  logic [N-1:0] sh_q;

  // Newest bit enters at the top, so the oldest bit of a frame ends at bit 0
  assign next_o = {ser_i, sh_q[N-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= next_o;
  end

  AST_BIT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sh_q[N-1] == $past(ser_i))); // R1
  AST_BIT_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sh_q[N-2:0] == $past(sh_q[N-1:1]))); // R4
endmodule

// File: rtl/s2p_word_reg.sv
module s2p_word_reg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] word_i,
  output logic [N-1:0] data_o,
  output logic         valid_o
);
  logic [N-1:0] data_q;
  logic         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) data_q <= word_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  AST_LOAD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (data_o == $past(word_i))); // R3
endmodule

// File: rtl/ser2par_deser.sv
module ser2par_deser #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic [N-1:0] data_o,
  output logic         valid_o
);
  import ser2par_pkg::*;

  logic         last;
  logic [N-1:0] next_word;

  initial AST_N_POW2: assert (is_pow2(N)); // R8

  s2p_frame_ctr #(.N(N)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_o (last)
  );

  s2p_shift_reg #(.N(N)) u_sh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .next_o (next_word)
  );

  s2p_word_reg #(.N(N)) u_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (last),
    .word_i  (next_word),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R6
  AST_VALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_LAST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (data_o[N-1] == $past(ser_i))); // R4

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_CLEAR: assert (data_o == '0 && !valid_o); // R7
  end
endmodule

// File: tb/ser2par_deser_bench.sv
module ser2par_deser_bench;
  localparam int N      = 8;
  localparam int CLK_PS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser = 1'b0;
  logic [N-1:0] data;
  logic         valid;
  int           n_run = 0;
  int           n_fail = 0;
  logic [N-1:0] prev_word = '0;

  always #(CLK_PS / 2) clk = ~clk;

  ser2par_deser #(.N(N)) u_ser2par_deser (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .ser_i   (ser),
    .data_o  (data),
    .valid_o (valid)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one bit before the next rising edge, then sample at the falling edge
  task automatic push(input logic b);
    ser = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [N-1:0] w);
    for (int i = 0; i < N; i++) begin
      push(w[i]);
      if (i < N - 1) begin
        chk("R5 valid low mid-frame", N'(valid), '0);
        chk("R6 data held mid-frame", data, prev_word);
      end
    end
    chk("R3/R4 frame word", data, w);
    chk("R5 valid strobe", N'(valid), N'(1));
    prev_word = w;
  endtask

  initial begin
    #(CLK_PS * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset data", data, '0);
    chk("R7 reset valid", N'(valid), '0);
    rst_n = 1'b1;
    // R1 R2 R8: every pattern of the default 8-bit frame, back to back
    for (int f = 0; f < (1 << N); f++) send_frame(N'(f));
    // R6: after the last frame, the first bit of a new frame drops valid and holds data
    push(1'b1);
    chk("R5 valid drops after strobe", N'(valid), '0);
    chk("R6 hold after strobe", data, prev_word);
    push(1'b0);
    push(1'b1);
    // R7: reset in the middle of a frame discards the partial frame
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 mid-stream reset data", data, '0);
    chk("R7 mid-stream reset valid", N'(valid), '0);
    rst_n = 1'b1;
    prev_word = '0;
    send_frame(N'(8'hA5));
    send_frame(N'(8'h3C));
    push(1'b0);
    chk("R5 valid single cycle", N'(valid), '0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule